// File: doc/BRIEF.md
# Hash compression-step vector unit

This block runs a single step of a hash compression round on a small vector register file. The file holds thirty-two 128-bit registers. Each cycle the unit can accept one 32-bit instruction word. When the word's fixed opcode bits match and the feature-enable input is high, the unit computes a new 128-bit value and writes it back to the destination register.

The computation reads three registers: the destination, a second source and a third source. From the third source it takes one 32-bit lane, selected by a 2-bit index. The new top word is a modular sum of four 32-bit terms:

- the XOR of the destination's three upper words;
- the destination's low word;
- a shifted mix formed from the second source's top word and a rotation of the destination's top word;
- the selected lane.

The lower three result words are a permutation of the destination's words, and one of them is rotated.

If a matching word arrives while the feature is disabled, the unit raises an undefined-instruction flag and writes nothing. A debug port loads and reads registers, so software models or test logic can set up operands and observe results.

Top module: `hstep_vec_unit`

## Requirements
- R1: The word decodes as the operation only when bits 31:21 are 11001110010, bits 15:14 are 10 and bits 11:10 are 00.
- R2: The destination index, which is also the first source, is in bits 4:0. The second source index is in bits 9:5, the lane index in bits 13:12 and the third source index in bits 20:16.
- R3: When `insn_valid_i` is high with a matching word and `feat_en_i` is low, `undef_o` is high for the following cycle and no register changes.
- R4: A valid word that does not match leaves every register unchanged and keeps `undef_o` low, whatever `feat_en_i` is.
- R5: The lane W is the 32-bit lane of the third source chosen by the index: lane 0 is bits 31:0, lane 1 is bits 63:32, lane 2 is bits 95:64 and lane 3 is bits 127:96.
- R6: The result bits 127:96 are the sum, modulo 2^32, of four terms: (D[63:32] ^ D[95:64] ^ D[127:96]), D[31:0], (N[127:96] ^ rotl(D[127:96],12)) and W. Here D is the destination and N is the second source.
- R7: The result bits 95:64 are D[127:96], the result bits 63:32 are rotl(D[95:64],9), and the result bits 31:0 are D[63:32].
- R8: All operands are read before the write. A second or third source that names the destination sees the destination's old value.
- R9: The 128-bit result replaces the destination on the clock edge that samples the valid, enabled, matching word. The debug read port shows it from then on, and the source registers are unchanged.
- R10: An active-low asynchronous reset clears every register to zero and clears `undef_o`.
- R11: A debug write stores `dbg_wdata_i` at the next edge. If an instruction writes the same register in the same cycle, the instruction result wins. A debug write to a different register in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | Instruction word valid this cycle |
| insn_i | input | 32 | Instruction word |
| feat_en_i | input | 1 | Operation enabled |
| undef_o | output | 1 | Matching word issued while disabled (registered) |
| dbg_we_i | input | 1 | Debug register write enable |
| dbg_waddr_i | input | 5 | Debug write register index |
| dbg_wdata_i | input | 128 | Debug write data |
| dbg_raddr_i | input | 5 | Debug read register index |
| dbg_rdata_o | output | 128 | Debug read data (combinational) |

## Verification
The bench aliases the destination onto both sources. A design that read operands after the write, or that forwarded the result, would then compute from the wrong words. All-ones operands force several carries out of bit 31, which exposes an adder that is wider than 32 bits or that drops a term. Every lane index is exercised against distinct lane contents, and near-miss words flip single opcode bits. Together these catch a lane swap, a misplaced field, or a decoder that ignores a fixed bit. A disabled issue checks both the one-cycle flag and the untouched register. A debug write that collides with a writeback to the same register shows which port wins.

// File: rtl/hstep_pkg.sv
package hstep_pkg;
  localparam int REG_AW  = 5;
  localparam int LANE_W  = 2;
  localparam int WORD_W  = 32;
  localparam int NLANES  = 4;
  localparam int VEC_W   = WORD_W * NLANES;

  localparam logic [10:0] OP_HI  = 11'b11001110010;
  localparam logic [1:0]  OP_MID = 2'b10;
  localparam logic [1:0]  OP_LO  = 2'b00;

  typedef struct packed {
    logic              hit;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src_b;
    logic [REG_AW-1:0] src_c;
    logic [LANE_W-1:0] lane;
  } dec_t;
endpackage

// File: rtl/hstep_decode.sv
module hstep_decode
  import hstep_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.hit   = (insn_i[31:21] == OP_HI) && (insn_i[15:14] == OP_MID) &&
                  (insn_i[11:10] == OP_LO);
    dec_o.src_c = insn_i[20:16];
    dec_o.lane  = insn_i[13:12];
    dec_o.src_b = insn_i[9:5];
    dec_o.dst   = insn_i[4:0];
  end
endmodule

// File: rtl/hstep_datapath.sv
module hstep_datapath #(
  parameter int WORD_W = 32,
  parameter int ROT_MIX = 12,
  parameter int ROT_PERM = 9,
  localparam int NLANES = 4,
  localparam int VEC_W = WORD_W * NLANES,
  localparam int LANE_W = $clog2(NLANES)
) (
  input  logic [VEC_W-1:0]  d_i,
  input  logic [WORD_W-1:0] b_top_i,
  input  logic [VEC_W-1:0]  c_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [VEC_W-1:0]  res_o
);
  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int s);
    return (x << s) | (x >> (WORD_W - s));
  endfunction

  logic [WORD_W-1:0] dw [NLANES];
  logic [WORD_W-1:0] lane_w, shift_mix, xor3, top_sum;

  for (genvar g = 0; g < NLANES; g++) begin : g_split
    assign dw[g] = d_i[g*WORD_W +: WORD_W];
  end

  always_comb begin
    lane_w    = c_i[lane_i*WORD_W +: WORD_W];
    shift_mix = b_top_i ^ rotl(dw[3], ROT_MIX);
    xor3      = dw[1] ^ dw[2] ^ dw[3];
    top_sum   = xor3 + dw[0] + shift_mix + lane_w;  // wraps mod 2^WORD_W
    res_o     = {top_sum, dw[3], rotl(dw[2], ROT_PERM), dw[1]};
  end
endmodule

// File: rtl/hstep_regfile.sv
module hstep_regfile #(
  parameter int NREG = 32,
  parameter int DW = 128,
  parameter int TW = 32,
  parameter int NRP = 3,
  localparam int AW = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pa_en_i,   // priority write port
  input  logic [AW-1:0]            pa_addr_i,
  input  logic [DW-1:0]            pa_data_i,
  input  logic                     pb_en_i,
  input  logic [AW-1:0]            pb_addr_i,
  input  logic [DW-1:0]            pb_data_i,
  input  logic [NRP-1:0][AW-1:0]   raddr_i,
  output logic [NRP-1:0][DW-1:0]   rdata_o,
  input  logic [AW-1:0]            taddr_i,   // narrow top-word read
  output logic [TW-1:0]            tdata_o
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (pa_en_i && pa_addr_i == AW'(g))    q <= pa_data_i;
      else if (pb_en_i && pb_addr_i == AW'(g))    q <= pb_data_i;
    end
    assign regs[g] = q;
  end

  for (genvar r = 0; r < NRP; r++) begin : g_rd
    assign rdata_o[r] = regs[raddr_i[r]];
  end

  assign tdata_o = regs[taddr_i][DW-1 -: TW];
endmodule

// File: rtl/hstep_vec_unit.sv
module hstep_vec_unit
  import hstep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_valid_i,
  input  logic [31:0]       insn_i,
  input  logic              feat_en_i,
  output logic              undef_o,
  input  logic              dbg_we_i,
  input  logic [REG_AW-1:0] dbg_waddr_i,
  input  logic [VEC_W-1:0]  dbg_wdata_i,
  input  logic [REG_AW-1:0] dbg_raddr_i,
  output logic [VEC_W-1:0]  dbg_rdata_o
);
  localparam int NREG = 1 << REG_AW;
  localparam int NRP  = 3;

  dec_t                        dec;
  logic                        wb_en, undef_d;
  logic [NRP-1:0][REG_AW-1:0]  raddr;
  logic [NRP-1:0][VEC_W-1:0]   rdata;
  logic [WORD_W-1:0]           b_top;
  logic [VEC_W-1:0]            result;

  hstep_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  assign wb_en   = insn_valid_i && dec.hit && feat_en_i;
  assign undef_d = insn_valid_i && dec.hit && !feat_en_i;

  // port 0: destination, 1: third source, 2: debug
  assign raddr = {dbg_raddr_i, dec.src_c, dec.dst};

  hstep_regfile #(.NREG(NREG), .DW(VEC_W), .TW(WORD_W), .NRP(NRP)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pa_en_i  (wb_en),
    .pa_addr_i(dec.dst),
    .pa_data_i(result),
    .pb_en_i  (dbg_we_i),
    .pb_addr_i(dbg_waddr_i),
    .pb_data_i(dbg_wdata_i),
    .raddr_i  (raddr),
    .rdata_o  (rdata),
    .taddr_i  (dec.src_b),
    .tdata_o  (b_top)
  );

  hstep_datapath #(.WORD_W(WORD_W)) u_dp (
    .d_i    (rdata[0]),
    .b_top_i(b_top),
    .c_i    (rdata[1]),
    .lane_i (dec.lane),
    .res_o  (result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) undef_o <= 1'b0;
    else         undef_o <= undef_d;
  end

  assign dbg_rdata_o = rdata[2];
endmodule

// File: rtl/hstep_vec_unit_chk.sv
module hstep_vec_unit_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         insn_valid_i,
  input logic [10:0]  op_hi_i,
  input logic [1:0]   op_mid_i,
  input logic [1:0]   op_lo_i,
  input logic         feat_en_i,
  input logic         undef_o,
  input logic         wb_en,
  input logic         dbg_we_i,
  input logic [4:0]   dbg_waddr_i,
  input logic [127:0] dbg_wdata_i,
  input logic [4:0]   dbg_raddr_i,
  input logic [127:0] dbg_rdata_o
);
  logic pat;
  assign pat = (op_hi_i == 11'b11001110010) && (op_mid_i == 2'b10) && (op_lo_i == 2'b00);

  p_undef_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && pat && !feat_en_i) |=> undef_o);

  p_undef_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!insn_valid_i || !pat) |=> !undef_o);

  p_no_wb_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !feat_en_i |-> !wb_en);

  p_wb_needs_issue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en |-> (insn_valid_i && pat));

  p_dbg_write_lands_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_we_i && !wb_en && dbg_raddr_i == dbg_waddr_i) |=>
      (!$stable(dbg_raddr_i) || dbg_rdata_o == $past(dbg_wdata_i)));
endmodule

bind hstep_vec_unit hstep_vec_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .insn_valid_i(insn_valid_i),
  .op_hi_i     (insn_i[31:21]),
  .op_mid_i    (insn_i[15:14]),
  .op_lo_i     (insn_i[11:10]),
  .feat_en_i   (feat_en_i),
  .undef_o     (undef_o),
  .wb_en       (wb_en),
  .dbg_we_i    (dbg_we_i),
  .dbg_waddr_i (dbg_waddr_i),
  .dbg_wdata_i (dbg_wdata_i),
  .dbg_raddr_i (dbg_raddr_i),
  .dbg_rdata_o (dbg_rdata_o)
);

// File: tb/hstep_vec_unit_test.sv
module hstep_vec_unit_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         insn_valid_i = 1'b0;
  logic [31:0]  insn_i = '0;
  logic         feat_en_i = 1'b1;
  logic         undef_o;
  logic         dbg_we_i = 1'b0;
  logic [4:0]   dbg_waddr_i = '0;
  logic [127:0] dbg_wdata_i = '0;
  logic [4:0]   dbg_raddr_i = '0;
  logic [127:0] dbg_rdata_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  hstep_vec_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .insn_valid_i(insn_valid_i), .insn_i(insn_i),
    .feat_en_i(feat_en_i), .undef_o(undef_o), .dbg_we_i(dbg_we_i),
    .dbg_waddr_i(dbg_waddr_i), .dbg_wdata_i(dbg_wdata_i),
    .dbg_raddr_i(dbg_raddr_i), .dbg_rdata_o(dbg_rdata_o)
  );

  function automatic logic [31:0] rl(logic [31:0] x, int s);
    logic [63:0] t;
    t = {x, x} << s;
    return t[63:32];
  endfunction

  function automatic logic [127:0] model(logic [127:0] d, logic [127:0] n,
                                         logic [127:0] m, logic [1:0] ln);
    logic [31:0] w, s, t;
    case (ln)
      2'd0: w = m[31:0];
      2'd1: w = m[63:32];
      2'd2: w = m[95:64];
      default: w = m[127:96];
    endcase
    s = n[127:96] ^ rl(d[127:96], 12);
    t = 32'((64'(d[63:32] ^ d[95:64] ^ d[127:96]) + 64'(d[31:0]) + 64'(s) + 64'(w)) & 64'hFFFF_FFFF);
    return {t, d[127:96], rl(d[95:64], 9), d[63:32]};
  endfunction

  function automatic logic [31:0] enc(logic [4:0] rd, logic [4:0] rn, logic [4:0] rm, logic [1:0] ln);
    return {11'b11001110010, rm, 2'b10, ln, 2'b00, rn, rd};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic dbg_wr(logic [4:0] a, logic [127:0] v);
    @(negedge clk);
    dbg_we_i = 1'b1; dbg_waddr_i = a; dbg_wdata_i = v;
    @(negedge clk);
    dbg_we_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [127:0] v);
    dbg_raddr_i = a;
    #1 v = dbg_rdata_o;
  endtask

  // drives one issue cycle; returns undef_o sampled after the edge
  task automatic issue(logic [31:0] w, logic en, output logic u);
    @(negedge clk);
    insn_valid_i = 1'b1; insn_i = w; feat_en_i = en;
    @(negedge clk);
    insn_valid_i = 1'b0; feat_en_i = 1'b1;
    u = undef_o;
  endtask

  task automatic t_reset;
    logic [127:0] v;
    chk("R10 undef after reset", 128'(undef_o), 128'd0);
    for (int i = 0; i < 32; i += 7) begin
      rd(5'(i), v);
      chk("R10 reg zero after reset", v, '0);
    end
  endtask

  task automatic t_lanes;
    logic [127:0] d, n, m, v;
    logic u;
    d = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    n = 128'hdead_beef_0bad_f00d_1357_9bdf_2468_ace0;
    m = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    for (int l = 0; l < 4; l++) begin
      dbg_wr(5'd1, d); dbg_wr(5'd2, n); dbg_wr(5'd3, m);
      issue(enc(5'd1, 5'd2, 5'd3, 2'(l)), 1'b1, u);
      rd(5'd1, v);
      chk($sformatf("R5 R6 R7 R9 lane %0d result", l), v, model(d, n, m, 2'(l)));
      chk("R2 R9 undef low on enabled issue", 128'(u), 128'd0);
      rd(5'd2, v); chk("R9 second source intact", v, n);
      rd(5'd3, v); chk("R9 third source intact", v, m);
    end
    // fields placed at other indices
    dbg_wr(5'd30, d); dbg_wr(5'd17, n); dbg_wr(5'd8, m);
    issue(enc(5'd30, 5'd17, 5'd8, 2'd2), 1'b1, u);
    rd(5'd30, v);
    chk("R1 R2 field positions", v, model(d, n, m, 2'd2));
  endtask

  task automatic t_alias;
    logic [127:0] d, v;
    logic u;
    d = 128'h8000_0001_7fff_fffe_c0de_cafe_0f0f_f0f0;
    dbg_wr(5'd4, d);
    issue(enc(5'd4, 5'd4, 5'd4, 2'd3), 1'b1, u);
    rd(5'd4, v);
    chk("R8 all operands alias destination", v, model(d, d, d, 2'd3));
  endtask

  task automatic t_wrap;
    logic [127:0] d, n, m, v;
    logic u;
    d = '1; n = '1; m = '1;
    dbg_wr(5'd9, d); dbg_wr(5'd10, n); dbg_wr(5'd11, m);
    issue(enc(5'd9, 5'd10, 5'd11, 2'd0), 1'b1, u);
    rd(5'd9, v);
    chk("R6 modular wrap all ones", v, model(d, n, m, 2'd0));
  endtask

  task automatic t_disabled;
    logic [127:0] d, v;
    logic u;
    d = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    dbg_wr(5'd12, d);
    issue(enc(5'd12, 5'd13, 5'd14, 2'd1), 1'b0, u);
    chk("R3 undef raised", 128'(u), 128'd1);
    rd(5'd12, v);
    chk("R3 destination unchanged", v, d);
    @(negedge clk);
    chk("R3 undef lasts one cycle", 128'(undef_o), 128'd0);
  endtask

  task automatic t_nomatch;
    logic [127:0] d, v;
    logic u;
    logic [31:0] base;
    d = 128'habcd_ef01_2345_6789_abcd_ef01_2345_6789;
    dbg_wr(5'd15, d); dbg_wr(5'd16, 128'h5);
    base = enc(5'd15, 5'd16, 5'd16, 2'd0);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] w;
      case (k)
        0: w = base ^ 32'h0000_4000;   // bits 15:14 -> 11
        1: w = base ^ 32'h0000_8000;   // bits 15:14 -> 00
        2: w = base ^ 32'h0000_0400;   // bit 10 set
        3: w = base ^ 32'h0000_0800;   // bit 11 set
        4: w = base ^ 32'h0020_0000;   // bit 21 flipped
        default: w = base ^ 32'h8000_0000; // bit 31 flipped
      endcase
      issue(w, k[0], u);
      rd(5'd15, v);
      chk($sformatf("R1 R4 near-miss %0d no write", k), v, d);
      chk($sformatf("R4 near-miss %0d no undef", k), 128'(u), 128'd0);
    end
  endtask

  task automatic t_collide;
    logic [127:0] d, n, m, v;
    d = 128'h0bad_cafe_dead_beef_1234_5678_9abc_def0;
    n = 128'h7777_0000_0000_0000_0000_0000_0000_0000;
    m = 128'h0000_0000_0000_0000_0000_0000_5a5a_5a5a;
    dbg_wr(5'd20, d); dbg_wr(5'd21, n); dbg_wr(5'd22, m);
    @(negedge clk);
    insn_valid_i = 1'b1; insn_i = enc(5'd20, 5'd21, 5'd22, 2'd0);
    dbg_we_i = 1'b1; dbg_waddr_i = 5'd20; dbg_wdata_i = '1;
    @(negedge clk);
    insn_valid_i = 1'b0; dbg_we_i = 1'b0;
    rd(5'd20, v);
    chk("R11 instruction wins same register", v, model(d, n, m, 2'd0));
    dbg_wr(5'd20, d);
    @(negedge clk);
    insn_valid_i = 1'b1; insn_i = enc(5'd20, 5'd21, 5'd22, 2'd0);
    dbg_we_i = 1'b1; dbg_waddr_i = 5'd23; dbg_wdata_i = 128'hfeed;
    @(negedge clk);
    insn_valid_i = 1'b0; dbg_we_i = 1'b0;
    rd(5'd20, v);
    chk("R11 writeback alongside debug write", v, model(d, n, m, 2'd0));
    rd(5'd23, v);
    chk("R11 debug write other register", v, 128'hfeed);
  endtask

  task automatic t_reset_mid;
    logic [127:0] v;
    dbg_wr(5'd31, 128'h99);
    #2 rst_ni = 1'b0;
    #1 rd(5'd31, v);
    chk("R10 async clear", v, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    rd(5'd20, v);
    chk("R10 other register cleared", v, '0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_alias();
    t_wrap();
    t_disabled();
    t_nomatch();
    t_collide();
    t_reset_mid();
    done = 1;
    finish_run();
  end
endmodule